// File: doc/BRIEF.md
# Wait-State Bus Master Sequencer

This block issues single read and write accesses on a synchronous parallel bus with separate address, data and control lines. A local requester hands it one command at a time (address, direction, write data) over a valid/ready handshake. The sequencer then drives the address, a select strobe and either the read or the write strobe. It holds them steady while the target stretches the access by keeping its ready line low. It finishes when ready is seen high, or aborts when a watchdog limit is passed. Each access ends with a one-cycle completion pulse that carries a two-bit status code, the captured read data and the number of stall cycles the access spent.

Targets may report a fault together with ready. A flag that comes with the fault separates an absent target, which the requester may retry, from a protection violation, which it must trap. The ready input can be taken either straight or through a two-flop synchronizer, chosen by a parameter, for targets that run from another clock. An asynchronous active-low reset drops every strobe the moment it asserts, even in the middle of an access.

The sequencer has three states. `ST_IDLE` waits for a command. `ST_ADDR` is the first cycle of an access. `ST_WAIT` covers each further cycle in which ready has not yet been seen. There are five transitions. *accept* goes from `ST_IDLE` to `ST_ADDR` on a handshake. *stall* goes from `ST_ADDR` or `ST_WAIT` to `ST_WAIT` when ready is low and the limit is not yet passed. *finish* goes from `ST_ADDR` or `ST_WAIT` to `ST_IDLE` when ready is seen high. *abort* goes from `ST_ADDR` or `ST_WAIT` to `ST_IDLE` when the watchdog expires. *reset* returns to `ST_IDLE` from any state.

Top module: `wsbm_master`

## Requirements
- R1: `cmd_ready` is high only in `ST_IDLE` while the ready value the sequencer samples (synchronized or direct) is low. In the cycle after a handshake, `bus_sel` is high, exactly one of `bus_rd` (`cmd_write`=0) or `bus_wr` (`cmd_write`=1) is high, `bus_addr`/`bus_wdata` show the command, and `cmd_ready` is low.
- R2: While an access is open (ready sampled low), `bus_addr`, `bus_wdata`, `bus_rd` and `bus_wr` do not change.
- R3: At the clock edge where ready is sampled high, the access ends: in the next cycle `bus_sel`, `bus_rd` and `bus_wr` are low and `rsp_done` is high. `rsp_rdata` is loaded from `bus_rdata` only at such an edge of a read; writes and timeouts leave it unchanged.
- R4: Status codes: 2'b00 success, 2'b01 retryable (fault with `bus_prot`=0), 2'b10 trap (fault with `bus_prot`=1), 2'b11 timeout. `bus_err` and `bus_prot` are sampled at the same edge as ready.
- R5: N is `timeout_limit`, captured at the handshake. The access is aborted at the N+1-th consecutive low ready sample, reporting status 2'b11 and `rsp_waits` = N+1. With N=0 the first low sample aborts.
- R6: For an access that is not aborted, `rsp_waits` equals the number of edges at which ready was sampled low; it holds until the next completion.
- R7: With `SYNC_READY`=1, ready passes through two flops, so a target that holds ready low for W edges of the access costs W+2 stall samples. With `SYNC_READY`=0 it costs W.
- R8: While `rst_n` is low, `bus_sel`, `bus_rd`, `bus_wr` and `rsp_done` are low at once, `rsp_status`, `rsp_waits` and `rsp_rdata` are zero, and `cmd_ready` is high.
- R9: Every accepted command yields exactly one `rsp_done` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with `cmd_valid` |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Command address |
| cmd_wdata | input | DW | Write data |
| timeout_limit | input | CW | Watchdog limit N, captured at handshake |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | Completion status code |
| rsp_rdata | output | DW | Last captured read data |
| rsp_waits | output | CW+1 | Stall cycles of the last access |
| bus_sel | output | 1 | Select strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_ready | input | 1 | Target ready, low inserts wait states |
| bus_err | input | 1 | Target fault, valid with ready |
| bus_prot | input | 1 | Fault kind: 1 protection, 0 absent |
| bus_rdata | input | DW | Target read data, valid with ready |

## Verification
The bench builds two copies with AW=8, DW=8 and CW=3. One takes ready directly (`SYNC_READY`=0) and the other through the synchronizer (`SYNC_READY`=1). Both receive the same commands in lockstep. A 3-bit limit keeps every watchdog value from 0 to 6 within reach. The sweep crosses target delays of 0 to 4 edges with every limit, both directions and all three fault responses. This puts each success, retry, trap and timeout boundary on both sides of the limit, and shows the two-sample synchronizer offset as a shifted timeout boundary. A reset asserted in the middle of a stalled access closes the run.

// File: rtl/wsbm_pkg.sv
package wsbm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        RSP_OK      = 2'b00,
        RSP_RETRY   = 2'b01,
        RSP_TRAP    = 2'b10,
        RSP_TIMEOUT = 2'b11
    } rsp_code_e;

    // Fault classification for a ready-high sample.
    function automatic rsp_code_e classify(input logic fault, input logic prot);
        if (!fault)    return RSP_OK;
        else if (prot) return RSP_TRAP;
        else           return RSP_RETRY;
    endfunction

endpackage

// File: rtl/wsbm_ready_sync.sv
module wsbm_ready_sync #(
    parameter bit SYNC_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    generate
        if (SYNC_EN) begin : g_two_flop
            logic [1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= 2'b00;
                else        stage_q <= {stage_q[0], async_i};
            end
            assign sync_o = stage_q[1];
        end else begin : g_direct
            assign sync_o = async_i;
        end
    endgenerate

endmodule

// File: rtl/wsbm_watchdog.sv
module wsbm_watchdog #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic [CW:0]   total_o,
    output logic          expired_o
);

    localparam int WW = CW + 1;

    logic [WW-1:0] cnt_q;

    // Expires on the low sample that would exceed the limit.
    assign expired_o = tick_i && (cnt_q == {1'b0, limit_i});
    assign total_o   = cnt_q + {{(WW-1){1'b0}}, tick_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (tick_i && !expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wsbm_resp.sv
module wsbm_resp
    import wsbm_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          finish_i,
    input  rsp_code_e     code_i,
    input  logic [CW:0]   waits_i,
    input  logic          load_rdata_i,
    input  logic [DW-1:0] rdata_i,
    output logic          done_o,
    output logic [1:0]    status_o,
    output logic [CW:0]   waits_o,
    output logic [DW-1:0] rdata_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            status_o <= 2'b00;
            waits_o  <= '0;
            rdata_o  <= '0;
        end else begin
            done_o <= finish_i;
            if (finish_i) begin
                status_o <= code_i;
                waits_o  <= waits_i;
            end
            if (load_rdata_i) begin
                rdata_o <= rdata_i;
            end
        end
    end

endmodule

// File: rtl/wsbm_master.sv
module wsbm_master
    import wsbm_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int CW         = 8,
    parameter bit SYNC_READY = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic [CW-1:0] timeout_limit,
    output logic          rsp_done,
    output logic [1:0]    rsp_status,
    output logic [DW-1:0] rsp_rdata,
    output logic [CW:0]   rsp_waits,
    output logic          bus_sel,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ready,
    input  logic          bus_err,
    input  logic          bus_prot,
    input  logic [DW-1:0] bus_rdata
);

    localparam int WW = CW + 1;

    seq_state_e    state_q, state_d;
    logic          rdy_s;
    logic          accept, in_access, tick, hit, expired, finish;
    logic          write_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [CW-1:0] limit_q;
    logic [WW-1:0] total;
    rsp_code_e     code;

    wsbm_ready_sync #(.SYNC_EN(SYNC_READY)) u_rdy_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (bus_ready),
        .sync_o  (rdy_s)
    );

    assign in_access = (state_q != ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign tick      = in_access && !rdy_s;
    assign hit       = in_access && rdy_s;
    assign finish    = hit || expired;
    assign code      = expired ? RSP_TIMEOUT : classify(bus_err, bus_prot);

    wsbm_watchdog #(.CW(CW)) u_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (accept),
        .tick_i    (tick),
        .limit_i   (limit_q),
        .total_o   (total),
        .expired_o (expired)
    );

    wsbm_resp #(.DW(DW), .CW(CW)) u_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .finish_i     (finish),
        .code_i       (code),
        .waits_i      (total),
        .load_rdata_i (hit && !write_q),
        .rdata_i      (bus_rdata),
        .done_o       (rsp_done),
        .status_o     (rsp_status),
        .waits_o      (rsp_waits),
        .rdata_o      (rsp_rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept, stall, finish, abort
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_ADDR;
            end
            ST_ADDR, ST_WAIT: begin
                if (finish) state_d = ST_IDLE;
                else        state_d = ST_WAIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Command latch, loaded only on a handshake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            limit_q <= '0;
        end else if (accept) begin
            write_q <= cmd_write;
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
            limit_q <= timeout_limit;
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        cmd_ready = (state_q == ST_IDLE) && !rdy_s;
        bus_sel   = in_access;
        bus_rd    = in_access && !write_q;
        bus_wr    = in_access && write_q;
        bus_addr  = addr_q;
        bus_wdata = wdata_q;
    end

endmodule

// File: rtl/wsbm_master_checker.sv
module wsbm_master_checker #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          cmd_write,
    input logic [AW-1:0] cmd_addr,
    input logic          rsp_done,
    input logic [1:0]    rsp_status,
    input logic [CW:0]   rsp_waits,
    input logic          bus_sel,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [CW-1:0] limit_q
);

    assert_accept_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (bus_sel && (bus_rd != bus_wr)
            && (bus_addr == $past(cmd_addr)) && (bus_wr == $past(cmd_write))));

    assert_strobe_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd, bus_wr}));

    assert_idle_no_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !bus_sel);

    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && $past(bus_sel)) |-> ($stable(bus_addr) && $stable(bus_wdata)
            && $stable(bus_rd) && $stable(bus_wr)));

    assert_done_after_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!bus_sel && $past(bus_sel)));

    assert_timeout_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && (rsp_status == 2'b11)) |-> (rsp_waits == ({1'b0, limit_q} + 1'b1)));

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

bind wsbm_master wsbm_master_checker #(.AW(AW), .DW(DW), .CW(CW)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_write  (cmd_write),
    .cmd_addr   (cmd_addr),
    .rsp_done   (rsp_done),
    .rsp_status (rsp_status),
    .rsp_waits  (rsp_waits),
    .bus_sel    (bus_sel),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .limit_q    (limit_q)
);

// File: tb/wsbm_master_bench.sv
module wsbm_master_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr  = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic [CW-1:0] limit     = '0;
    logic          t_err = 1'b0, t_prot = 1'b0;
    int            tgt_wait = 0;

    logic [1:0]    crdy, done, sel, rd, wr, rdy_in;
    logic [1:0]    status [2];
    logic [CW:0]   waits  [2];
    logic [DW-1:0] rdata  [2];
    logic [AW-1:0] baddr  [2];
    logic [DW-1:0] bwdata [2];
    logic [DW-1:0] tdata  [2];

    wsbm_master #(.AW(AW), .DW(DW), .CW(CW), .SYNC_READY(1'b0)) u_wsbm_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(crdy[0]),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .timeout_limit(limit), .rsp_done(done[0]), .rsp_status(status[0]),
        .rsp_rdata(rdata[0]), .rsp_waits(waits[0]), .bus_sel(sel[0]),
        .bus_rd(rd[0]), .bus_wr(wr[0]), .bus_addr(baddr[0]), .bus_wdata(bwdata[0]),
        .bus_ready(rdy_in[0]), .bus_err(t_err), .bus_prot(t_prot), .bus_rdata(tdata[0]));

    wsbm_master #(.AW(AW), .DW(DW), .CW(CW), .SYNC_READY(1'b1)) u_wsbm_master_sync (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(crdy[1]),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .timeout_limit(limit), .rsp_done(done[1]), .rsp_status(status[1]),
        .rsp_rdata(rdata[1]), .rsp_waits(waits[1]), .bus_sel(sel[1]),
        .bus_rd(rd[1]), .bus_wr(wr[1]), .bus_addr(baddr[1]), .bus_wdata(bwdata[1]),
        .bus_ready(rdy_in[1]), .bus_err(t_err), .bus_prot(t_prot), .bus_rdata(tdata[1]));

    // Target models: ready rises after tgt_wait edges of the access
    for (genvar g = 0; g < 2; g++) begin : g_tgt
        logic [3:0] cnt;
        always @(posedge clk) begin
            if (!sel[g]) cnt <= 4'd0;
            else if (cnt != 4'hF) cnt <= cnt + 4'd1;
        end
        assign rdy_in[g] = sel[g] && (int'(cnt) >= tgt_wait);
        assign tdata[g]  = baddr[g] ^ 8'h5A;
    end

    int compared = 0, mismatched = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor at the falling edge
    bit            got [2];
    int            dcnt [2];
    bit            hold_bad [2];
    bit            sel_at_done [2];
    logic [1:0]    m_status [2];
    logic [CW:0]   m_waits [2];
    logic [DW-1:0] m_rdata [2];
    logic [AW-1:0] exp_addr = '0;
    logic [DW-1:0] exp_wdata = '0;
    bit            exp_write = 1'b0;

    always @(negedge clk) begin
        for (int g = 0; g < 2; g++) begin
            if (done[g]) begin
                got[g] = 1'b1;
                dcnt[g]++;
                m_status[g] = status[g];
                m_waits[g] = waits[g];
                m_rdata[g] = rdata[g];
                if (sel[g]) sel_at_done[g] = 1'b1;
            end
            if (sel[g] && (baddr[g] != exp_addr || bwdata[g] != exp_wdata
                           || rd[g] != !exp_write || wr[g] != exp_write))
                hold_bad[g] = 1'b1;
        end
    end

    logic [DW-1:0] prev_rd [2];

    task automatic run_txn(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int wt, input int lim, input int ek);
        int guard;
        tgt_wait = wt;
        t_err = (ek != 0);
        t_prot = (ek == 2);
        limit = lim[CW-1:0];
        guard = 0;
        while (!(crdy[0] && crdy[1]) && guard < 20) begin
            @(negedge clk); #1;
            guard++;
        end
        exp_addr = a; exp_wdata = d; exp_write = w;
        for (int g = 0; g < 2; g++) begin
            got[g] = 0; dcnt[g] = 0; hold_bad[g] = 0; sel_at_done[g] = 0;
        end
        cmd_write = w; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
        @(negedge clk); #1;
        cmd_valid = 1'b0;
        for (int g = 0; g < 2; g++) begin
            // R1: strobes and address in the cycle after the handshake
            chk(sel[g] && rd[g] == !w && wr[g] == w && baddr[g] == a && bwdata[g] == d
                && !crdy[g], "R1 drive after accept", {sel[g], rd[g], wr[g]}, {1'b1, !w, w});
        end
        guard = 0;
        while (!(got[0] && got[1]) && guard < 40) begin
            @(negedge clk); #1;
            guard++;
        end
        repeat (3) @(negedge clk);
        #1;
        for (int g = 0; g < 2; g++) begin
            int eff = wt + (g == 1 ? 2 : 0);
            int est, ewt;
            logic [DW-1:0] erd;
            if (eff > lim) begin
                est = 3; ewt = lim + 1; erd = prev_rd[g];
            end else begin
                est = ek; ewt = eff;
                erd = w ? prev_rd[g] : (a ^ 8'h5A);
            end
            prev_rd[g] = erd;
            chk(dcnt[g] == 1, "R9 one done pulse", dcnt[g], 1);
            if (eff > lim)
                chk(m_status[g] == est[1:0], "R5 timeout status", m_status[g], est);
            else
                chk(m_status[g] == est[1:0], "R4 status class", m_status[g], est);
            if (eff > lim)
                chk(int'(m_waits[g]) == ewt, "R5 timeout waits", m_waits[g], ewt);
            else if (g == 1)
                chk(int'(m_waits[g]) == ewt, "R7 synced stall count", m_waits[g], ewt);
            else
                chk(int'(m_waits[g]) == ewt, "R6 stall count", m_waits[g], ewt);
            chk(m_rdata[g] == erd, "R3 read data capture", m_rdata[g], erd);
            chk(!sel_at_done[g], "R3 strobes low at done", sel_at_done[g], 0);
            chk(!hold_bad[g], "R2 lines held while stalled", hold_bad[g], 0);
        end
    endtask

    task automatic reset_checks(input string tag);
        for (int g = 0; g < 2; g++) begin
            chk(!sel[g] && !rd[g] && !wr[g] && !done[g], {tag, " strobes"}, {sel[g], rd[g], wr[g]}, 0);
            chk(status[g] == 2'b00 && waits[g] == '0 && rdata[g] == '0, {tag, " response"},
                {status[g], waits[g], rdata[g]}, 0);
            chk(crdy[g], {tag, " cmd_ready"}, crdy[g], 1);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end

    initial begin
        prev_rd[0] = '0; prev_rd[1] = '0;
        repeat (3) @(negedge clk);
        #1;
        reset_checks("R8 initial reset");
        rst_n = 1'b1;
        @(negedge clk); #1;

        for (int w = 0; w < 2; w++)
            for (int wt = 0; wt < 5; wt++)
                for (int lim = 0; lim < 7; lim++)
                    for (int ek = 0; ek < 3; ek++)
                        run_txn(w[0], 8'(wt * 37 + lim * 11 + ek * 3 + w),
                                8'(lim * 29 + wt * 7 + ek), wt, lim, ek);

        // Reset in the middle of a stalled read
        tgt_wait = 9; limit = 3'd7; t_err = 1'b0; t_prot = 1'b0;
        exp_addr = 8'hC3; exp_wdata = 8'h00; exp_write = 1'b0;
        cmd_write = 1'b0; cmd_addr = 8'hC3; cmd_wdata = 8'h00; cmd_valid = 1'b1;
        @(negedge clk); #1;
        cmd_valid = 1'b0;
        chk(sel[0] && sel[1], "R8 access open before reset", {sel[1], sel[0]}, 3);
        @(negedge clk);
        #2 rst_n = 1'b0;
        #1;
        reset_checks("R8 mid-access reset");
        @(negedge clk); #1;
        rst_n = 1'b1;
        prev_rd[0] = '0; prev_rd[1] = '0;
        @(negedge clk); #1;
        run_txn(1'b0, 8'h3C, 8'h00, 1, 4, 0);

        finished = 1'b1;
        summary();
    end

endmodule